// File: doc/BRIEF.md
# Low-Power Mode Entry/Exit Controller

This block is the power-management sequencer of a small CPU subsystem. When the CPU issues a sleep request, the block reads three control bits and picks a low-power state: light sleep, software standby, or, for an unsupported combination, no change with an error flag. The state it is in decides three enables: the CPU clock, the peripheral clocks and the oscillator.

The block watches the interrupt request, enable and CPU-mask inputs and the non-maskable interrupt, and leaves each low-power state only on the wake sources that state accepts. Light sleep resumes at once. Software standby first turns the oscillator back on and counts out a settling time chosen by a 3-bit select, then resumes. Both exits pulse the start-interrupt-handling output.

Two pins override the rest. A low reset pin forces a reset state, which waits for the settling time and for the pin to rise before it pulses the start-reset-handling output. A low standby pin forces hardware standby, which only a reset can end.

Top module: `lpm_ctrl`

## Requirements
- R1: A `sleep_req` in the run state with `stby_sel`=0 and `lowspd_on`=0 moves the block to light sleep on the next edge. In light sleep `cpu_clk_en`=0, `per_clk_en`=1 and `osc_en`=1.
- R2: A `sleep_req` in the run state with `stby_sel`=1, `lowspd_on`=0 and `wdt_pss`=0 moves the block to software standby on the next edge. In that state all three enables are 0.
- R3: Light sleep ends on `nmi`, or on any bit with `irq_req`=1, `irq_en`=1 and `cpu_mask`=0. On that edge the block returns to run and `start_irq` is high for exactly one cycle, with no settling wait.
- R4: In light sleep, a request whose enable bit is 0, or any maskable request while `cpu_mask`=1, leaves the block asleep.
- R5: Software standby ends only on `nmi` or on a qualified request on IRQ bit 0, 1, 2, 6 or 7. A request on bit 3, 4 or 5 is ignored.
- R6: A valid wake from software standby enters the settling state with `osc_en`=1 and both clock enables 0. The block stays there for 2^(6+`settle_sel`) cycles, then returns to run with a one-cycle `start_irq` pulse.
- R7: With `stby_n`=1, `res_n`=0 moves any other state to the reset state on the next edge (`osc_en`=1, clock enables 0). The block leaves after at least 2^(6+`settle_sel`) cycles there, on the first edge at which the count is done and `res_n`=1. It then returns to run with a one-cycle `start_rst` pulse.
- R8: `stby_n`=0 moves the block to hardware standby on the next edge from any state, with priority over `res_n` and every other input. All enables are 0 there.
- R9: Hardware standby is left only when `stby_n`=1 and `res_n`=0, which enters the reset state.
- R10: A `sleep_req` in run with any other control combination keeps the block in run and sets `cfg_err`, which stays set until `rst`.
- R11: `state_o` encodes run=0, light sleep=1, software standby=2, settling=3, reset=4, hardware standby=5.
- R12: Synchronous `rst` puts the block in run with all enables 1, both pulses 0 and `cfg_err` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_req | input | 1 | CPU sleep instruction strobe |
| stby_sel | input | 1 | Control bit: select standby instead of sleep |
| lowspd_on | input | 1 | Control bit: low-speed mode request |
| wdt_pss | input | 1 | Control bit: watchdog prescaler select |
| settle_sel | input | 3 | Oscillator settling select |
| irq_req | input | 8 | Maskable interrupt requests |
| irq_en | input | 8 | Per-request enable bits |
| cpu_mask | input | 1 | CPU masks all maskable requests |
| nmi | input | 1 | Non-maskable interrupt |
| res_n | input | 1 | Reset pin, active low |
| stby_n | input | 1 | Standby pin, active low |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Oscillator enable |
| start_irq | output | 1 | One-cycle pulse: begin interrupt handling |
| start_rst | output | 1 | One-cycle pulse: begin reset handling |
| cfg_err | output | 1 | Sticky flag for an unsupported sleep combination |
| state_o | output | 3 | Current state code |

## Verification
The sharpest collision is a wake interrupt and a falling reset pin in the same cycle. The bench drives `nmi` and `res_n`=0 together while the block is in light sleep, and the right outcome is the reset state with no `start_irq` pulse. A second collision drives both pins low at once in hardware standby: the standby pin has to win, and the state code must not move. The behavioural model sets the expected outcome of every such cycle from the stated priority order and compares it with the outputs on every clock.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    localparam int NUM_IRQ  = 8;
    localparam int SEL_W    = 3;
    localparam int BASE_EXP = 6;
    localparam int CNT_W    = BASE_EXP + (1 << SEL_W) - 1;
    localparam logic [NUM_IRQ-1:0] DEEP_WAKE_MASK = 8'b1100_0111;

    typedef enum logic [2:0] {
        ST_RUN    = 3'd0,
        ST_SLEEP  = 3'd1,
        ST_SSTBY  = 3'd2,
        ST_SETTLE = 3'd3,
        ST_RESET  = 3'd4,
        ST_HWSTBY = 3'd5
    } lpm_state_e;

    typedef enum logic [1:0] {
        ENT_SLEEP = 2'd0,
        ENT_SSTBY = 2'd1,
        ENT_BAD   = 2'd2
    } entry_e;

    typedef struct packed {
        logic cpu;
        logic per;
        logic osc;
    } clk_gate_t;

    function automatic clk_gate_t gate_for(lpm_state_e s);
        clk_gate_t g;
        case (s)
            ST_RUN:    g = '{cpu: 1'b1, per: 1'b1, osc: 1'b1};
            ST_SLEEP:  g = '{cpu: 1'b0, per: 1'b1, osc: 1'b1};
            ST_SETTLE: g = '{cpu: 1'b0, per: 1'b0, osc: 1'b1};
            ST_RESET:  g = '{cpu: 1'b0, per: 1'b0, osc: 1'b1};
            default:   g = '{cpu: 1'b0, per: 1'b0, osc: 1'b0};
        endcase
        return g;
    endfunction

    function automatic entry_e decode_entry(logic ssel, logic lspd, logic pss);
        if (!ssel && !lspd)
            return ENT_SLEEP;
        else if (ssel && !lspd && !pss)
            return ENT_SSTBY;
        else
            return ENT_BAD;
    endfunction

    function automatic logic [CNT_W-1:0] settle_load(logic [SEL_W-1:0] sel);
        int v;
        v = (1 << (BASE_EXP + int'(sel))) - 1;
        return CNT_W'(v);
    endfunction

endpackage

// File: rtl/lpm_wake.sv
module lpm_wake
    import lpm_pkg::*;
#(
    parameter int N_IRQ = NUM_IRQ,
    parameter logic [N_IRQ-1:0] DEEP_MASK = DEEP_WAKE_MASK
) (
    input  logic [N_IRQ-1:0] irq_req,
    input  logic [N_IRQ-1:0] irq_en,
    input  logic             cpu_mask,
    input  logic             nmi,
    output logic             wake_light,
    output logic             wake_deep
);

    logic [N_IRQ-1:0] qual;
    logic [N_IRQ-1:0] qual_deep;

    for (genvar i = 0; i < N_IRQ; i++) begin : g_qual
        assign qual[i]      = irq_req[i] & irq_en[i] & ~cpu_mask;
        assign qual_deep[i] = qual[i] & DEEP_MASK[i];
    end

    assign wake_light = nmi | (|qual);
    assign wake_deep  = nmi | (|qual_deep);

endmodule

// File: rtl/lpm_settle_cnt.sv
module lpm_settle_cnt #(
    parameter int W = 13
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         done
);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (dec && cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);

endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm
    import lpm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sleep_req,
    input  entry_e     entry,
    input  logic       wake_light,
    input  logic       wake_deep,
    input  logic       res_n,
    input  logic       stby_n,
    input  logic       cnt_done,
    output logic       cnt_load,
    output logic       cnt_dec,
    output lpm_state_e state,
    output logic       irq_pulse,
    output logic       rst_pulse,
    output logic       err_flag
);

    lpm_state_e nxt;
    logic       irq_set;
    logic       rst_set;
    logic       err_set;

    always_comb begin
        nxt      = state;
        cnt_load = 1'b0;
        cnt_dec  = 1'b0;
        irq_set  = 1'b0;
        rst_set  = 1'b0;
        err_set  = 1'b0;
        if (!stby_n) begin
            nxt = ST_HWSTBY;
        end else if (!res_n && state != ST_RESET) begin
            nxt      = ST_RESET;
            cnt_load = 1'b1;
        end else begin
            case (state)
                ST_RUN: begin
                    if (sleep_req) begin
                        case (entry)
                            ENT_SLEEP: nxt = ST_SLEEP;
                            ENT_SSTBY: nxt = ST_SSTBY;
                            default:   err_set = 1'b1;
                        endcase
                    end
                end
                ST_SLEEP: begin
                    if (wake_light) begin
                        nxt     = ST_RUN;
                        irq_set = 1'b1;
                    end
                end
                ST_SSTBY: begin
                    if (wake_deep) begin
                        nxt      = ST_SETTLE;
                        cnt_load = 1'b1;
                    end
                end
                ST_SETTLE: begin
                    if (cnt_done) begin
                        nxt     = ST_RUN;
                        irq_set = 1'b1;
                    end else begin
                        cnt_dec = 1'b1;
                    end
                end
                ST_RESET: begin
                    if (!cnt_done) begin
                        cnt_dec = 1'b1;
                    end else if (res_n) begin
                        nxt     = ST_RUN;
                        rst_set = 1'b1;
                    end
                end
                ST_HWSTBY: nxt = ST_HWSTBY;
                default:   nxt = ST_RUN;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_RUN;
            irq_pulse <= 1'b0;
            rst_pulse <= 1'b0;
            err_flag  <= 1'b0;
        end else begin
            state     <= nxt;
            irq_pulse <= irq_set;
            rst_pulse <= rst_set;
            if (err_set)
                err_flag <= 1'b1;
        end
    end

endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
    import lpm_pkg::*;
#(
    parameter int N_IRQ = NUM_IRQ,
    parameter logic [N_IRQ-1:0] DEEP_MASK = DEEP_WAKE_MASK
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sleep_req,
    input  logic             stby_sel,
    input  logic             lowspd_on,
    input  logic             wdt_pss,
    input  logic [SEL_W-1:0] settle_sel,
    input  logic [N_IRQ-1:0] irq_req,
    input  logic [N_IRQ-1:0] irq_en,
    input  logic             cpu_mask,
    input  logic             nmi,
    input  logic             res_n,
    input  logic             stby_n,
    output logic             cpu_clk_en,
    output logic             per_clk_en,
    output logic             osc_en,
    output logic             start_irq,
    output logic             start_rst,
    output logic             cfg_err,
    output logic [2:0]       state_o
);

    logic       wake_light;
    logic       wake_deep;
    logic       cnt_load;
    logic       cnt_dec;
    logic       cnt_done;
    lpm_state_e state;
    entry_e     entry;
    clk_gate_t  gate;

    assign entry = decode_entry(stby_sel, lowspd_on, wdt_pss);

    lpm_wake #(.N_IRQ(N_IRQ), .DEEP_MASK(DEEP_MASK)) u_wake (
        .irq_req    (irq_req),
        .irq_en     (irq_en),
        .cpu_mask   (cpu_mask),
        .nmi        (nmi),
        .wake_light (wake_light),
        .wake_deep  (wake_deep)
    );

    lpm_settle_cnt #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (cnt_load),
        .load_val (settle_load(settle_sel)),
        .dec      (cnt_dec),
        .done     (cnt_done)
    );

    lpm_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .sleep_req  (sleep_req),
        .entry      (entry),
        .wake_light (wake_light),
        .wake_deep  (wake_deep),
        .res_n      (res_n),
        .stby_n     (stby_n),
        .cnt_done   (cnt_done),
        .cnt_load   (cnt_load),
        .cnt_dec    (cnt_dec),
        .state      (state),
        .irq_pulse  (start_irq),
        .rst_pulse  (start_rst),
        .err_flag   (cfg_err)
    );

    assign gate       = gate_for(state);
    assign cpu_clk_en = gate.cpu;
    assign per_clk_en = gate.per;
    assign osc_en     = gate.osc;
    assign state_o    = state;

endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       nmi,
    input logic       res_n,
    input logic       stby_n,
    input logic [7:0] irq_req,
    input logic [7:0] irq_en,
    input logic       cpu_mask,
    input logic       cpu_clk_en,
    input logic       per_clk_en,
    input logic       osc_en,
    input logic       start_irq,
    input logic       start_rst,
    input logic [2:0] state_o
);

    logic [7:0] deep_q;
    assign deep_q = irq_req & irq_en & 8'b1100_0111 & {8{~cpu_mask}};

    AST_SLEEP_GATES: assert property (@(posedge clk) disable iff (rst)
        state_o == 3'd1 |-> (!cpu_clk_en && per_clk_en && osc_en)); // R1

    AST_SSTBY_GATES: assert property (@(posedge clk) disable iff (rst)
        state_o == 3'd2 |-> (!cpu_clk_en && !per_clk_en && !osc_en)); // R2

    AST_NMI_WAKES_SLEEP: assert property (@(posedge clk) disable iff (rst)
        (state_o == 3'd1 && nmi && stby_n && res_n) |=> (start_irq && state_o == 3'd0)); // R3

    AST_SSTBY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state_o == 3'd2 && !nmi && deep_q == 8'd0 && stby_n && res_n) |=> state_o == 3'd2); // R5

    AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (rst)
        $rose(start_irq) |-> ($past(state_o) == 3'd1 || $past(state_o) == 3'd3)); // R6

    AST_RES_PIN: assert property (@(posedge clk) disable iff (rst)
        (stby_n && !res_n) |=> state_o == 3'd4); // R7

    AST_STBY_PIN: assert property (@(posedge clk) disable iff (rst)
        !stby_n |=> (state_o == 3'd5 && !osc_en && !start_irq && !start_rst)); // R8

    AST_ONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({start_irq, start_rst})); // R11

endmodule

bind lpm_ctrl lpm_ctrl_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .nmi        (nmi),
    .res_n      (res_n),
    .stby_n     (stby_n),
    .irq_req    (irq_req),
    .irq_en     (irq_en),
    .cpu_mask   (cpu_mask),
    .cpu_clk_en (cpu_clk_en),
    .per_clk_en (per_clk_en),
    .osc_en     (osc_en),
    .start_irq  (start_irq),
    .start_rst  (start_rst),
    .state_o    (state_o)
);

// File: tb/lpm_ctrl_tb.sv
module lpm_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 20000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sleep_req = 1'b0, stby_sel = 1'b0, lowspd_on = 1'b0, wdt_pss = 1'b0;
    logic [2:0] settle_sel = 3'd0;
    logic [7:0] irq_req = 8'd0, irq_en = 8'd0;
    logic       cpu_mask = 1'b0, nmi = 1'b0, res_n = 1'b1, stby_n = 1'b1;
    logic       cpu_clk_en, per_clk_en, osc_en, start_irq, start_rst, cfg_err;
    logic [2:0] state_o;

    int  checks = 0;
    int  errors = 0;
    int  cycles = 0;
    bit  cmp_en = 1'b0;
    bit  done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    lpm_ctrl u_dut (
        .clk(clk), .rst(rst), .sleep_req(sleep_req), .stby_sel(stby_sel),
        .lowspd_on(lowspd_on), .wdt_pss(wdt_pss), .settle_sel(settle_sel),
        .irq_req(irq_req), .irq_en(irq_en), .cpu_mask(cpu_mask), .nmi(nmi),
        .res_n(res_n), .stby_n(stby_n), .cpu_clk_en(cpu_clk_en),
        .per_clk_en(per_clk_en), .osc_en(osc_en), .start_irq(start_irq),
        .start_rst(start_rst), .cfg_err(cfg_err), .state_o(state_o)
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_sim();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Behavioural reference model
    int m_st = 0;
    int m_cnt = 0;
    bit m_irq = 0, m_rst = 0, m_err = 0;

    always @(posedge clk) begin
        bit wl, wd;
        wl = nmi || ((irq_req & irq_en) != 0 && !cpu_mask);
        wd = nmi || ((irq_req & irq_en & 8'hC7) != 0 && !cpu_mask);
        if (rst) begin
            m_st = 0; m_cnt = 0; m_irq = 0; m_rst = 0; m_err = 0;
        end else begin
            m_irq = 0; m_rst = 0;
            if (!stby_n) begin
                m_st = 5;
            end else if (!res_n && m_st != 4) begin
                m_st = 4; m_cnt = (1 << (6 + settle_sel)) - 1;
            end else if (m_st == 0) begin
                if (sleep_req) begin
                    if (!stby_sel && !lowspd_on) m_st = 1;
                    else if (stby_sel && !lowspd_on && !wdt_pss) m_st = 2;
                    else m_err = 1;
                end
            end else if (m_st == 1) begin
                if (wl) begin m_st = 0; m_irq = 1; end
            end else if (m_st == 2) begin
                if (wd) begin m_st = 3; m_cnt = (1 << (6 + settle_sel)) - 1; end
            end else if (m_st == 3) begin
                if (m_cnt == 0) begin m_st = 0; m_irq = 1; end
                else m_cnt--;
            end else if (m_st == 4) begin
                if (m_cnt != 0) m_cnt--;
                else if (res_n) begin m_st = 0; m_rst = 1; end
            end
        end
    end

    always @(negedge clk) begin
        cycles++;
        if (cycles > WD_LIMIT) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, WD_LIMIT);
            finish_sim();
        end
        if (cmp_en) begin
            chk("R11 state_o", state_o, m_st);
            chk("R1 cpu_clk_en", cpu_clk_en, m_st == 0);
            chk("R2 per_clk_en", per_clk_en, m_st <= 1);
            chk("R6 osc_en", osc_en, m_st == 0 || m_st == 1 || m_st == 3 || m_st == 4);
            chk("R3 start_irq", start_irq, m_irq);
            chk("R7 start_rst", start_rst, m_rst);
            chk("R10 cfg_err", cfg_err, m_err);
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_sleep(bit ss, bit ls, bit pss);
        stby_sel = ss; lowspd_on = ls; wdt_pss = pss; sleep_req = 1'b1;
        cyc(1);
        sleep_req = 1'b0;
        cyc(1);
    endtask

    initial begin
        cyc(3);
        rst = 1'b0;
        cmp_en = 1'b1;
        cyc(1);
        // R12: reset state
        chk("R12 state after rst", state_o, 0);
        chk("R12 enables after rst", {cpu_clk_en, per_clk_en, osc_en}, 3'b111);

        // R1 light sleep entry, R4 ignored requests, R3 wake
        do_sleep(0, 0, 0);
        chk("R1 in sleep", state_o, 1);
        irq_req = 8'h08; irq_en = 8'h00; cyc(5);
        chk("R4 disabled irq ignored", state_o, 1);
        irq_en = 8'h08; cpu_mask = 1'b1; cyc(5);
        chk("R4 masked irq ignored", state_o, 1);
        cpu_mask = 1'b0; cyc(1);
        chk("R3 woke and pulsed", {state_o, start_irq}, {3'd0, 1'b1});
        irq_req = 8'h00; irq_en = 8'h00; cyc(2);

        // R10 bad combination
        do_sleep(0, 1, 0);
        chk("R10 stays run", state_o, 0);
        chk("R10 flag set", cfg_err, 1);
        do_sleep(1, 0, 1);
        chk("R10 pss combo stays run", state_o, 0);

        // R2 software standby, R5 ignored bits, R6 settle
        settle_sel = 3'd0;
        do_sleep(1, 0, 0);
        chk("R2 in standby", state_o, 2);
        irq_req = 8'h38; irq_en = 8'h38; cyc(6);
        chk("R5 bits 3-5 ignored", state_o, 2);
        irq_req = 8'h40; irq_en = 8'h40; cyc(1);
        chk("R6 settling", {state_o, osc_en}, {3'd3, 1'b1});
        irq_req = 8'h00; irq_en = 8'h00;
        cyc(62);
        chk("R6 still settling", state_o, 3);
        cyc(2);
        chk("R6 back to run", state_o, 0);
        cyc(2);

        // R5/R6 wake by nmi with longer settle
        settle_sel = 3'd2;
        do_sleep(1, 0, 0);
        nmi = 1'b1; cyc(1); nmi = 1'b0;
        cyc(300);
        chk("R6 long settle done", state_o, 0);

        // R7 reset pin: short low pulse, then waits out settling
        settle_sel = 3'd0;
        res_n = 1'b0; cyc(10); res_n = 1'b1; cyc(20);
        chk("R7 waiting settle", state_o, 4);
        cyc(60);
        chk("R7 reset done", state_o, 0);
        // R7 long low pulse
        res_n = 1'b0; cyc(100);
        chk("R7 held in reset", state_o, 4);
        res_n = 1'b1; cyc(3);
        chk("R7 released", state_o, 0);

        // R8 hardware standby from sleep; R9 exit via reset
        do_sleep(0, 0, 0);
        stby_n = 1'b0; cyc(2);
        chk("R8 hw standby", state_o, 5);
        res_n = 1'b0; cyc(3);
        chk("R8 standby pin has priority", state_o, 5);
        res_n = 1'b1; stby_n = 1'b1; nmi = 1'b1; cyc(3); nmi = 1'b0;
        chk("R9 no exit without reset", state_o, 5);
        res_n = 1'b0; cyc(2);
        chk("R9 exits to reset", state_o, 4);
        res_n = 1'b1; cyc(70);
        chk("R9 back to run", state_o, 0);

        // Collision: wake and reset pin in the same cycle (R7 wins over R3)
        do_sleep(0, 0, 0);
        nmi = 1'b1; res_n = 1'b0; cyc(1);
        chk("R7 reset beats wake", {state_o, start_irq}, {3'd4, 1'b0});
        nmi = 1'b0; res_n = 1'b1; cyc(70);
        chk("R7 recovered", state_o, 0);

        // R12 reset clears sticky flag
        rst = 1'b1; cyc(2); rst = 1'b0; cyc(1);
        chk("R12 flag cleared", cfg_err, 0);

        cyc(2);
        finish_sim();
    end

endmodule